// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the four interrupt sources of one serial channel into a single interrupt line and a 4-bit identification code. The four sources are line status, receive data or receive timeout, transmit holding empty, and modem status. A 4-bit enable word gates each source on its own. The identification code names only the most urgent pending source. A lower source is hidden until every higher one has cleared. Receive data and receive timeout are both enabled by one bit and share one level. When both are present, the timeout code wins.

The other three sources arrive as levels and the block does not store them. The transmit-empty source is held inside the block as a pending flag. This flag is set at reset, because the holding register starts empty. It is set again when the holding-empty level rises. It is cleared by a write to the holding register, or by a read of the identification code while transmit-empty is the code being shown. Because of the reset value, enabling the transmit-empty source after reset raises the interrupt at once. The line and the code are combinational functions of the inputs and of the pending flag, so they always change together.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held, and right after it with no source enabled, the code is 0001 and irq is 0. After reset the transmit-empty flag is pending, so setting enable bit 1 alone gives code 0010 with irq 1 in that same cycle.
- R2: Each enable bit gates one source: bit 0 gates receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A source whose bit is 0 affects neither irq nor the code.
- R3: Line status (code 0110) takes precedence over every other source.
- R4: Receive timeout (code 1100) is reported ahead of receive data (code 0100). Both rank below line status and above transmit empty.
- R5: Transmit empty (code 0010) ranks above modem status (code 0000).
- R6: irq is 1 exactly when the code differs from 0001, and both change in the same cycle.
- R7: A read strobe that arrives while the code is 0010 clears the transmit-empty flag from the next cycle on. This holds unless the holding-empty level rises at that same edge.
- R8: A read strobe that arrives while some other code is shown leaves the transmit-empty flag pending.
- R9: A holding-register write strobe clears the transmit-empty flag from the next cycle on, and it wins over everything else. A later rising edge on the holding-empty input sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 4 | Enable bits for the sources |
| line_stat | input | 1 | Line status condition |
| rx_data | input | 1 | Receive data ready condition |
| rx_tmo | input | 1 | Receive timeout condition |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_stat | input | 1 | Modem status condition |
| iir_rd | input | 1 | Identification code read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt line |
| iir_code | output | 4 | Identification code of the highest pending source |

## Verification
Changes on the source levels and the enable word reach irq and the code within the same cycle, with no register on the path. The bench drives them on the falling edge and compares one time unit later. The read and write strobes, and a rise of the holding-empty level, act through one register. Their result is due in the cycle after the rising edge that samples them. The bench's model of the pending flag moves at that same edge, so the next falling-edge comparison sees the new value.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IID_W    = 4;
  localparam int EN_W     = 4;
  localparam int NUM_SRC  = 5;
  localparam int LVL_LINE = 0;
  localparam int LVL_RXTO = 1;
  localparam int LVL_RXDA = 2;
  localparam int LVL_TX   = 3;
  localparam int LVL_MDM  = 4;

  typedef logic [IID_W-1:0] iid_t;

  localparam iid_t IID_NONE  = 4'b0001;
  localparam iid_t IID_LINE  = 4'b0110;
  localparam iid_t IID_RXTO  = 4'b1100;
  localparam iid_t IID_RXDA  = 4'b0100;
  localparam iid_t IID_TX    = 4'b0010;
  localparam iid_t IID_MODEM = 4'b0000;

  function automatic iid_t level_code(input int lvl);
    case (lvl)
      LVL_LINE: level_code = IID_LINE;
      LVL_RXTO: level_code = IID_RXTO;
      LVL_RXDA: level_code = IID_RXDA;
      LVL_TX:   level_code = IID_TX;
      default:  level_code = IID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import uart_irq_pkg::*;
(
  input  logic [EN_W-1:0]    en,
  input  logic               line_stat,
  input  logic               rx_tmo,
  input  logic               rx_data,
  input  logic               tx_pend,
  input  logic               modem_stat,
  output logic [NUM_SRC-1:0] req
);
  always_comb begin
    req           = '0;
    req[LVL_LINE] = en[2] & line_stat;
    req[LVL_RXTO] = en[0] & rx_tmo;
    req[LVL_RXDA] = en[0] & rx_data;
    req[LVL_TX]   = en[1] & tx_pend;
    req[LVL_MDM]  = en[3] & modem_stat;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] req,
  output iid_t         code,
  output logic         any,
  output logic [N-1:0] grant
);
  always_comb begin
    code  = IID_NONE;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        code     = level_code(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/irq_tx_track.sv
module irq_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic iir_rd,
  input  logic tx_shown,
  output logic pend
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = thr_empty & ~prev_q;

  always_comb begin
    prev_d = thr_empty;
    pend_d = pend_q;
    if (thr_wr) begin
      pend_d = 1'b0;
    end else if (rise) begin
      pend_d = 1'b1;
    end else if (iir_rd && tx_shown) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] irq_en,
  input  logic            line_stat,
  input  logic            rx_data,
  input  logic            rx_tmo,
  input  logic            thr_empty,
  input  logic            modem_stat,
  input  logic            iir_rd,
  input  logic            thr_wr,
  output logic            irq,
  output logic [IID_W-1:0] iir_code
);
  logic               tx_pend;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  iid_t               code;
  logic               any;

  irq_src_gate u_gate (
    .en         (irq_en),
    .line_stat  (line_stat),
    .rx_tmo     (rx_tmo),
    .rx_data    (rx_data),
    .tx_pend    (tx_pend),
    .modem_stat (modem_stat),
    .req        (req)
  );

  irq_prio_enc #(.N(NUM_SRC)) u_enc (
    .req   (req),
    .code  (code),
    .any   (any),
    .grant (grant)
  );

  irq_tx_track u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_empty (thr_empty),
    .thr_wr    (thr_wr),
    .iir_rd    (iir_rd),
    .tx_shown  (grant[LVL_TX]),
    .pend      (tx_pend)
  );

  assign irq      = any;
  assign iir_code = code;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [EN_W-1:0] irq_en,
  input logic            line_stat,
  input logic            rx_data,
  input logic            rx_tmo,
  input logic            thr_empty,
  input logic            modem_stat,
  input logic            iir_rd,
  input logic            thr_wr,
  input logic            irq,
  input logic [IID_W-1:0] iir_code
);
  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[2] && line_stat) |-> (iir_code == IID_LINE));

  assert_tmo_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[0] && rx_tmo && !(irq_en[2] && line_stat)) |-> (iir_code == IID_RXTO));

  assert_irq_matches_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_code != IID_NONE));

  assert_no_enable_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  assert_read_clears_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_code == IID_TX && thr_empty && $past(thr_empty)) |=> (iir_code != IID_TX));

  assert_write_clears_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (iir_code != IID_TX));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] irq_en;
  logic       line_stat, rx_data, rx_tmo, thr_empty, modem_stat, iir_rd, thr_wr;
  logic       irq;
  logic [3:0] iir_code;

  int  n_run = 0;
  int  n_fail = 0;
  bit  m_pend, m_prev;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .line_stat(line_stat),
    .rx_data(rx_data), .rx_tmo(rx_tmo), .thr_empty(thr_empty),
    .modem_stat(modem_stat), .iir_rd(iir_rd), .thr_wr(thr_wr),
    .irq(irq), .iir_code(iir_code)
  );

  function automatic logic [3:0] exp_code(logic [3:0] en, bit ls, bit to, bit rd, bit tp, bit ms);
    if (en[2] && ls)      return 4'b0110;
    else if (en[0] && to) return 4'b1100;
    else if (en[0] && rd) return 4'b0100;
    else if (en[1] && tp) return 4'b0010;
    else if (en[3] && ms) return 4'b0000;
    else                  return 4'b0001;
  endfunction

  task automatic check(string req);
    logic [3:0] ec;
    ec = exp_code(irq_en, line_stat, rx_tmo, rx_data, m_pend, modem_stat);
    n_run++;
    if (iir_code !== ec || irq !== (ec != 4'b0001)) begin
      n_fail++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, iir_code, irq, ec, (ec != 4'b0001));
    end
  endtask

  task automatic model_edge();
    bit rise;
    logic [3:0] ec;
    ec = exp_code(irq_en, line_stat, rx_tmo, rx_data, m_pend, modem_stat);
    rise = thr_empty && !m_prev;
    if (thr_wr)                         m_pend = 0;
    else if (rise)                      m_pend = 1;
    else if (iir_rd && ec == 4'b0010)   m_pend = 0;
    m_prev = thr_empty;
  endtask

  task automatic drive(logic [3:0] en, bit ls, bit rd, bit to, bit te, bit ms, bit rdq, bit wr);
    irq_en = en; line_stat = ls; rx_data = rd; rx_tmo = to;
    thr_empty = te; modem_stat = ms; iir_rd = rdq; thr_wr = wr;
  endtask

  task automatic cyc(string req);
    #1;
    check(req);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    m_pend = 1; m_prev = 1;
    drive(4'h0, 0, 0, 0, 1, 0, 0, 0);
    @(negedge clk);
    #1 check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1");
    drive(4'b0010, 0, 0, 0, 1, 0, 0, 0); cyc("R1");
    drive(4'b0000, 1, 1, 1, 1, 1, 0, 0); cyc("R2");
    drive(4'b0100, 0, 1, 1, 1, 1, 0, 0); cyc("R2");
    drive(4'b1000, 0, 1, 1, 1, 1, 0, 0); cyc("R2");
    drive(4'b1111, 1, 1, 1, 1, 1, 0, 0); cyc("R3");
    drive(4'b1111, 0, 1, 1, 1, 1, 0, 0); cyc("R4");
    drive(4'b1111, 0, 1, 0, 1, 1, 0, 0); cyc("R4");
    drive(4'b1111, 0, 0, 0, 1, 1, 0, 0); cyc("R5");
    drive(4'b1111, 0, 1, 0, 1, 1, 1, 0); cyc("R8");
    drive(4'b1111, 0, 0, 0, 1, 1, 0, 0); cyc("R8");
    drive(4'b1111, 0, 0, 0, 1, 1, 1, 0); cyc("R6");
    drive(4'b1111, 0, 0, 0, 1, 1, 0, 0); cyc("R7");
    drive(4'b0010, 0, 0, 0, 0, 0, 0, 0); cyc("R7");
    drive(4'b0010, 0, 0, 0, 1, 0, 0, 0); cyc("R9");
    drive(4'b0010, 0, 0, 0, 1, 0, 0, 1); cyc("R9");
    drive(4'b0010, 0, 0, 0, 0, 0, 0, 0); cyc("R9");
    drive(4'b0010, 0, 0, 0, 1, 0, 0, 0); cyc("R9");
    drive(4'b0010, 0, 0, 0, 1, 0, 0, 0); cyc("R9");
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      drive(4'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 2) == 0),
            1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) == 0));
      cyc("R6");
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule